// File: doc/BRIEF.md
# Dual-Port Video Memory Model

This block models a video memory reached from two sides. A processor uses the random-access port to read or write one word at any row and column of the storage array. A row-transfer command loads every bit of one addressed row into an internal serial register in a single clock. A serial port then streams that row one bit per enabled serial clock. Meanwhile, the random-access port stays free for the processor.

All logic runs on one clock. The serial port advances only in cycles where its clock enable is high, so it can run at a lower rate than the random port. The default configuration has 8 rows of 256 bits, and each row is held as 32 words of 8 bits. Word `c` of a row holds row bits `8c` to `8c+7`, with bit 0 of the word at row bit `8c`. The serial register delivers row bits in ascending order. A transfer and a random access cannot share a cycle. When both are requested, the transfer is performed and the random access is held off.

Top module: `vidmem_dp`

## Requirements
- R1: A transfer of row `r` loads the whole row in one cycle. The stream that follows is the row as it stood at the transfer: row bit `k` is bit `k mod 8` of word `k/8`.
- R2: `ser_dout` changes only on an edge where `ser_en` is high and no transfer is requested. After the m-th such edge since a transfer, `ser_dout` equals row bit `m-1`.
- R3: `ser_ptr` is 0 after each transfer. Each shifting edge increments it by one, and the increment after 255 returns it to 0, so the stream restarts at row bit 0.
- R4: While `ser_en` is low and no transfer is requested, `ser_dout` and `ser_ptr` hold their values.
- R5: A read accepted on an edge raises `acc_rvalid` for the following cycle, with `acc_rdata` holding the addressed word. Before the edge, the write was the last one accepted to that word.
- R6: `acc_ready` is low in any cycle where `xfer_req` is high. An access presented in such a cycle has no effect: it writes nothing, and it raises no `acc_rvalid`.
- R7: Writes to the row currently held in the serial register do not change the bits still to be streamed.
- R8: While the serial port is shifting, random reads and writes complete every cycle with correct data.
- R9: After reset, `ser_ptr` is 0, `ser_dout` is 0 and `acc_rvalid` is 0.
- R10: When a transfer and `ser_en` are both high on the same edge, the transfer takes effect and `ser_dout` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | input | 1 | Row-transfer command |
| xfer_row | input | 3 | Row to transfer |
| acc_req | input | 1 | Random access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_row | input | 3 | Random access row |
| acc_col | input | 5 | Random access word column |
| acc_wdata | input | 8 | Write data |
| acc_ready | output | 1 | Access accepted this cycle |
| acc_rdata | output | 8 | Read data |
| acc_rvalid | output | 1 | Read data valid |
| ser_en | input | 1 | Serial clock enable |
| ser_dout | output | 1 | Serial output bit |
| ser_ptr | output | 8 | Serial tap pointer |

## Verification
The assertions assume that every control input is a known 0 or 1 once reset is released. They also assume that inputs change only between clock edges. The bench keeps to this by driving all inputs one time step after the rising edge, from idle defaults. The random-port data checks assume that no accepted write and read hit the same word on the same edge. The bench satisfies this by reading a different row from the one it overwrites while streaming.

// File: rtl/vidmem_dp.sv
module vidmem_dp #(
  parameter int ROWS     = 8,
  parameter int ROW_BITS = 256,
  parameter int WORD_W   = 8,
  localparam int COLS = ROW_BITS / WORD_W,
  localparam int RA   = $clog2(ROWS),
  localparam int CA   = $clog2(COLS),
  localparam int PA   = $clog2(ROW_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_req,
  input  logic [RA-1:0]     xfer_row,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [RA-1:0]     acc_row,
  input  logic [CA-1:0]     acc_col,
  input  logic [WORD_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic [WORD_W-1:0] acc_rdata,
  output logic              acc_rvalid,
  input  logic              ser_en,
  output logic              ser_dout,
  output logic [PA-1:0]     ser_ptr
);

  logic [ROW_BITS-1:0] mem [ROWS];
  logic [ROW_BITS-1:0] sreg;
  logic                acc_go;

  assign acc_ready = ~xfer_req;
  assign acc_go    = acc_req & acc_ready;

  always_ff @(posedge clk) begin
    if (acc_go && acc_we)
      mem[acc_row][acc_col*WORD_W +: WORD_W] <= acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rvalid <= 1'b0;
      acc_rdata  <= '0;
    end else begin
      acc_rvalid <= acc_go & ~acc_we;
      if (acc_go && !acc_we)
        acc_rdata <= mem[acc_row][acc_col*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg     <= '0;
      ser_ptr  <= '0;
      ser_dout <= 1'b0;
    end else if (xfer_req) begin
      sreg    <= mem[xfer_row];
      ser_ptr <= '0;
    end else if (ser_en) begin
      ser_dout <= sreg[ser_ptr];
      ser_ptr  <= (ser_ptr == PA'(ROW_BITS-1)) ? '0 : ser_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/vidmem_dp_chk.sv
module vidmem_dp_chk #(
  parameter int PA = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_req,
  input logic          acc_req,
  input logic          acc_we,
  input logic          acc_ready,
  input logic          acc_rvalid,
  input logic          ser_en,
  input logic          ser_dout,
  input logic [PA-1:0] ser_ptr
);

  p_ptr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> ser_ptr == '0);

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && !xfer_req) |=> ser_ptr == PA'($past(ser_ptr) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en && !xfer_req) |=> ($stable(ser_dout) && $stable(ser_ptr)));

  p_xfer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> $stable(ser_dout));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> !acc_rvalid);

  p_read_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_we && acc_ready) |=> acc_rvalid);

endmodule

bind vidmem_dp vidmem_dp_chk #(.PA($clog2(ROW_BITS))) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .acc_req(acc_req),
  .acc_we(acc_we), .acc_ready(acc_ready), .acc_rvalid(acc_rvalid),
  .ser_en(ser_en), .ser_dout(ser_dout), .ser_ptr(ser_ptr)
);

// File: tb/tb_vidmem_dp.sv
module tb_vidmem_dp;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8;
  localparam int COLS = 32;
  localparam int NBITS = 256;

  logic clk = 0, rst_n = 0;
  logic xfer_req = 0, acc_req = 0, acc_we = 0, ser_en = 0;
  logic [2:0] xfer_row = 0, acc_row = 0;
  logic [4:0] acc_col = 0;
  logic [7:0] acc_wdata = 0;
  logic acc_ready, acc_rvalid, ser_dout;
  logic [7:0] acc_rdata, ser_ptr;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] model [ROWS][COLS];
  logic [NBITS-1:0] snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  vidmem_dp dut (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_row(xfer_row),
    .acc_req(acc_req), .acc_we(acc_we), .acc_row(acc_row), .acc_col(acc_col),
    .acc_wdata(acc_wdata), .acc_ready(acc_ready), .acc_rdata(acc_rdata),
    .acc_rvalid(acc_rvalid), .ser_en(ser_en), .ser_dout(ser_dout), .ser_ptr(ser_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic idle;
    xfer_req = 0; acc_req = 0; acc_we = 0; ser_en = 0;
  endtask

  function automatic logic rowbit(input int r, input int k);
    return model[r][k/8][k%8];
  endfunction

  task automatic do_write(input int r, input int c, input logic [7:0] d);
    acc_req = 1; acc_we = 1; acc_row = 3'(r); acc_col = 5'(c); acc_wdata = d;
    tick; idle;
    model[r][c] = d;
  endtask

  task automatic do_read(input int r, input int c, input string req);
    acc_req = 1; acc_we = 0; acc_row = 3'(r); acc_col = 5'(c);
    tick; idle;
    chk(req, acc_rvalid, 1);
    chk(req, acc_rdata, model[r][c]);
  endtask

  task automatic do_xfer(input int r, input logic en);
    logic prev;
    prev = ser_dout;
    xfer_req = 1; xfer_row = 3'(r); ser_en = en;
    tick; idle;
    chk("R3 ptr after transfer", ser_ptr, 0);
    chk("R10 dout holds on transfer", ser_dout, prev);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick; tick;
    rst_n = 1;
    #1;
    chk("R9 ptr", ser_ptr, 0);
    chk("R9 dout", ser_dout, 0);
    chk("R9 rvalid", acc_rvalid, 0);

    // R5: fill all words, read back all
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        do_write(r, c, 8'((r*37 + c*11 + 5) ^ (c << 3)));
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        do_read(r, c, "R5 readback");
    tick;
    chk("R5 rvalid drops", acc_rvalid, 0);

    // R1/R2/R3: stream every row, wrap included
    for (int r = 0; r < ROWS; r++) begin
      do_xfer(r, (r % 2) == 1);
      for (int k = 0; k < NBITS; k++) begin
        ser_en = 1; tick; idle;
        chk("R1 R2 stream bit", ser_dout, rowbit(r, k));
        if (r == 0) chk("R3 ptr step", ser_ptr, (k + 1) % NBITS);
      end
      chk("R3 wrap to 0", ser_ptr, 0);
      ser_en = 1; tick; idle;
      chk("R3 restart bit0", ser_dout, rowbit(r, 0));
    end

    // R4: enable low holds output and pointer
    do_xfer(1, 0);
    for (int k = 0; k < 5; k++) begin ser_en = 1; tick; idle; end
    for (int k = 0; k < 6; k++) begin
      tick;
      chk("R4 dout hold", ser_dout, rowbit(1, 4));
      chk("R4 ptr hold", ser_ptr, 5);
    end

    // R7/R8: overwrite the loaded row while streaming, read another row
    do_xfer(2, 1);
    for (int k = 0; k < NBITS; k++) snap[k] = rowbit(2, k);
    for (int k = 0; k < NBITS; k++) begin
      ser_en = 1; acc_req = 1;
      if (k % 2 == 0) begin
        acc_we = 1; acc_row = 3'd2; acc_col = 5'((k/2) % COLS);
        acc_wdata = 8'hA5 ^ 8'((k/2) % COLS);
        tick; idle;
        model[2][(k/2) % COLS] = 8'hA5 ^ 8'((k/2) % COLS);
        chk("R8 rvalid low after write", acc_rvalid, 0);
      end else begin
        acc_we = 0; acc_row = 3'd5; acc_col = 5'(k % COLS);
        tick; idle;
        chk("R8 concurrent read valid", acc_rvalid, 1);
        chk("R8 concurrent read data", acc_rdata, model[5][k % COLS]);
      end
      chk("R7 stream unchanged by writes", ser_dout, snap[k]);
    end
    for (int c = 0; c < COLS; c++) do_read(2, c, "R8 concurrent writes landed");
    do_xfer(2, 0);
    for (int k = 0; k < 24; k++) begin
      ser_en = 1; tick; idle;
      chk("R1 new row contents", ser_dout, rowbit(2, k));
    end

    // R6: transfer stalls a write and a read
    xfer_req = 1; xfer_row = 3'd3; acc_req = 1; acc_we = 1;
    acc_row = 3'd4; acc_col = 5'd7; acc_wdata = ~model[4][7];
    #1;
    chk("R6 ready low", acc_ready, 0);
    tick; idle;
    do_read(4, 7, "R6 stalled write ignored");
    xfer_req = 1; acc_req = 1; acc_we = 0; acc_row = 3'd4; acc_col = 5'd7;
    tick; idle;
    chk("R6 stalled read no rvalid", acc_rvalid, 0);
    #1;
    chk("R6 ready high when idle", acc_ready, 1);

    // R10: transfer wins over enable
    for (int k = 0; k < 3; k++) begin ser_en = 1; tick; idle; end
    do_xfer(6, 1);
    ser_en = 1; tick; idle;
    chk("R10 first bit after transfer", ser_dout, rowbit(6, 0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule